// File: doc/BRIEF.md
# Localized Destination Traffic Generator

A synthetic traffic source for one core of a two-dimensional mesh (8 by 8 by default). Each cycle it is idle, it compares a pseudo-random byte with a programmable load fraction. If the byte is smaller, it starts a message. It then draws a second byte against a localization fraction to pick the destination class. A local destination is a core one hop away in Manhattan distance. A remote destination is any other core that is neither the source nor a one-hop neighbour.

Candidate coordinates come from the same free-running LFSR. A candidate that breaks the rule of its class is thrown away, and the next cycle's candidate is tried. When a candidate is accepted, the block streams a header flit followed by the data flits of the message on a valid/ready output. It starts no new message until the last flit of the current one has been taken. Back-pressure rule: once `out_valid` is high it stays high, with `out_data`, `out_head` and `out_last` unchanged, until a cycle in which `out_ready` is also high. A flit counts as transferred only in a cycle where both are high.

Top module: `loc_traffic_gen`

## Requirements
- R1: While reset is asserted and in the first cycle after it, `out_valid` is low.
- R2: In each idle cycle a message starts when an 8-bit random draw is strictly less than the 9-bit `load_frac`. A value of 0 never starts a message and no flit ever appears; 256 starts one on every idle cycle.
- R3: The class is local when an 8-bit random draw is strictly less than the 9-bit `local_frac`. With `local_frac` = 256 every header names a destination at Manhattan distance exactly 1 from the source.
- R4: A header never names the source itself. With `local_frac` = 0 every header names a destination at distance 2 or more.
- R5: A message is exactly 64 transferred flits. `out_head` is high on the first only and `out_last` on the 64th only. No header follows until the last flit is accepted, and `out_valid` is low in the cycle after that.
- R6: While `out_valid` is high and `out_ready` is low, the next cycle still shows `out_valid` high with `out_data` unchanged.
- R7: Header flit layout: bits [2:0] destination x, [5:3] destination y, [8:6] source x, [11:9] source y, and all higher bits zero.
- R8: Data flit k (k = 1..63) carries k in bits [5:0], source x in [8:6], source y in [11:9], and zeros above.
- R9: With an intermediate `local_frac` (128), both local and remote destinations occur over a long run.
- R10: Sources on a corner or an edge, which have only two or three neighbours, still complete resampling and keep producing local messages. The LFSR advances every cycle and never reaches the all-zero state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| load_frac | input | 9 | Injection probability per idle cycle, in units of 1/256 |
| local_frac | input | 9 | Probability of a local destination, in units of 1/256 |
| out_ready | input | 1 | Downstream can accept a flit |
| out_valid | output | 1 | A flit is presented |
| out_data | output | 32 | Flit contents |
| out_head | output | 1 | Presented flit is the header |
| out_last | output | 1 | Presented flit is the final flit of the message |

## Verification
Two instances run side by side under an all-local mode, an all-remote mode and a mixed mode: one sits on a corner with two neighbours, the other on an edge with three. A wrong classifier would let a second-hop or a source-equal header through. A broken redraw loop would leave the corner instance stuck in its draw with no messages. An off-by-one in the flit counter would show up as a misplaced `out_last`, a 63- or 65-flit message, or a header leaking in mid-message. Irregular ready patterns exercise long stalls, where a design that advanced on valid alone would skip or alter flits. Windows with zero load confirm that nothing is emitted and that no message is left half-sent.

// File: rtl/tg_pkg.sv
`timescale 1ns/1ps
package tg_pkg;
  typedef enum logic [1:0] {
    TG_IDLE = 2'd0,
    TG_DRAW = 2'd1,
    TG_SEND = 2'd2
  } tg_state_e;
endpackage

// File: rtl/tg_lfsr.sv
`timescale 1ns/1ps
module tg_lfsr #(
  parameter int          W    = 16,
  parameter logic [15:0] TAPS = 16'hB400,
  parameter logic [15:0] SEED = 16'hACE1
) (
  input  logic         clk,
  input  logic         rst_n,
  output logic [W-1:0] state
);
  localparam logic [W-1:0] TAPS_W = W'(TAPS);
  localparam logic [W-1:0] SEED_W = (W'(SEED) == '0) ? W'(1) : W'(SEED);

  always_ff @(posedge clk) begin
    if (!rst_n) state <= SEED_W;
    else if (state[0]) state <= (state >> 1) ^ TAPS_W;
    else state <= state >> 1;
  end

  // R10: the generator must never lock up in the zero state
  a_r10_lfsr_live: assert property (@(posedge clk) disable iff (!rst_n)
    state != '0);
  // R10: advances every cycle
  a_r10_lfsr_moves: assert property (@(posedge clk) disable iff (!rst_n)
    rst_n && $past(rst_n) |-> !$stable(state));
endmodule

// File: rtl/tg_dest_check.sv
`timescale 1ns/1ps
module tg_dest_check #(
  parameter int CW     = 3,
  parameter int MESH_X = 8,
  parameter int MESH_Y = 8,
  parameter int SRC_X  = 0,
  parameter int SRC_Y  = 0
) (
  input  logic [CW-1:0] cand_x,
  input  logic [CW-1:0] cand_y,
  input  logic          want_local,
  output logic          accept
);
  localparam logic [CW-1:0] SXL = CW'(SRC_X);
  localparam logic [CW-1:0] SYL = CW'(SRC_Y);

  logic [CW:0] dx, dy, hops;
  logic        in_mesh;

  always_comb begin
    dx      = (cand_x >= SXL) ? {1'b0, cand_x - SXL} : {1'b0, SXL - cand_x};
    dy      = (cand_y >= SYL) ? {1'b0, cand_y - SYL} : {1'b0, SYL - cand_y};
    hops    = dx + dy;
    in_mesh = (32'(cand_x) < MESH_X) && (32'(cand_y) < MESH_Y);
    if (want_local) accept = in_mesh && (hops == (CW+1)'(1));
    else            accept = in_mesh && (hops > (CW+1)'(1));
  end
endmodule

// File: rtl/tg_flit_sender.sv
`timescale 1ns/1ps
module tg_flit_sender #(
  parameter int FLIT_W    = 32,
  parameter int MSG_FLITS = 64,
  parameter int CW        = 3,
  parameter int SRC_X     = 0,
  parameter int SRC_Y     = 0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [CW-1:0]     dest_x,
  input  logic [CW-1:0]     dest_y,
  input  logic              out_ready,
  output logic              out_valid,
  output logic [FLIT_W-1:0] out_data,
  output logic              out_head,
  output logic              out_last,
  output logic              done
);
  localparam int IDX_W = $clog2(MSG_FLITS);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(MSG_FLITS - 1);
  localparam logic [CW-1:0] SXL = CW'(SRC_X);
  localparam logic [CW-1:0] SYL = CW'(SRC_Y);

  logic             active;
  logic [IDX_W-1:0] idx;
  logic [CW-1:0]    dx_q, dy_q;
  logic             xfer;

  assign xfer = active && out_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      active <= 1'b0;
      idx    <= '0;
      dx_q   <= '0;
      dy_q   <= '0;
    end else if (start && !active) begin
      active <= 1'b1;
      idx    <= '0;
      dx_q   <= dest_x;
      dy_q   <= dest_y;
    end else if (xfer) begin
      if (idx == LAST_IDX) begin
        active <= 1'b0;
        idx    <= '0;
      end else begin
        idx <= idx + 1'b1;
      end
    end
  end

  assign out_valid = active;
  assign out_head  = active && (idx == '0);
  assign out_last  = active && (idx == LAST_IDX);
  assign done      = xfer && (idx == LAST_IDX);

  always_comb begin
    if (idx == '0) out_data = FLIT_W'({SYL, SXL, dy_q, dx_q});
    else           out_data = FLIT_W'({SYL, SXL, idx});
  end

  // R6: a stalled flit stays presented
  a_r6_valid_held: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid);
  // R6: and its contents do not change
  a_r6_data_held: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> $stable(out_data) && $stable(out_head));
  // R5: a gap cycle follows the final accepted flit
  a_r5_gap_after_last: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !out_valid);
  // R5: no new message is launched over an active one
  a_r5_no_overlap: assert property (@(posedge clk) disable iff (!rst_n)
    start |-> !active);
endmodule

// File: rtl/loc_traffic_gen.sv
`timescale 1ns/1ps
module loc_traffic_gen #(
  parameter int          MESH_X    = 8,
  parameter int          MESH_Y    = 8,
  parameter int          CW        = 3,
  parameter int          SRC_X     = 0,
  parameter int          SRC_Y     = 0,
  parameter int          MSG_FLITS = 64,
  parameter int          FLIT_W    = 32,
  parameter int          FRAC_W    = 8,
  parameter int          LFSR_W    = 16,
  parameter logic [15:0] LFSR_TAPS = 16'hB400,
  parameter logic [15:0] LFSR_SEED = 16'hACE1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [FRAC_W:0]   load_frac,
  input  logic [FRAC_W:0]   local_frac,
  input  logic              out_ready,
  output logic              out_valid,
  output logic [FLIT_W-1:0] out_data,
  output logic              out_head,
  output logic              out_last
);
  import tg_pkg::*;

  localparam int CAND_LO = LFSR_W - 2*CW;

  tg_state_e         state;
  logic [LFSR_W-1:0] rnd;
  logic [FRAC_W-1:0] r_load, r_class;
  logic [CW-1:0]     cand_x, cand_y;
  logic              want_local_q;
  logic              cand_ok, start, done;

  tg_lfsr #(.W(LFSR_W), .TAPS(LFSR_TAPS), .SEED(LFSR_SEED)) u_lfsr (
    .clk(clk), .rst_n(rst_n), .state(rnd)
  );

  assign r_load  = rnd[FRAC_W-1:0];
  assign r_class = rnd[2*FRAC_W-1:FRAC_W];
  assign cand_x  = rnd[CAND_LO +: CW];
  assign cand_y  = rnd[CAND_LO+CW +: CW];

  tg_dest_check #(
    .CW(CW), .MESH_X(MESH_X), .MESH_Y(MESH_Y), .SRC_X(SRC_X), .SRC_Y(SRC_Y)
  ) u_check (
    .cand_x(cand_x), .cand_y(cand_y), .want_local(want_local_q), .accept(cand_ok)
  );

  assign start = (state == TG_DRAW) && cand_ok;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state        <= TG_IDLE;
      want_local_q <= 1'b0;
    end else begin
      case (state)
        TG_IDLE: if ({1'b0, r_load} < load_frac) begin
          state        <= TG_DRAW;
          want_local_q <= ({1'b0, r_class} < local_frac);
        end
        TG_DRAW: if (cand_ok) state <= TG_SEND;
        TG_SEND: if (done) state <= TG_IDLE;
        default: state <= TG_IDLE;
      endcase
    end
  end

  tg_flit_sender #(
    .FLIT_W(FLIT_W), .MSG_FLITS(MSG_FLITS), .CW(CW), .SRC_X(SRC_X), .SRC_Y(SRC_Y)
  ) u_send (
    .clk(clk), .rst_n(rst_n), .start(start), .dest_x(cand_x), .dest_y(cand_y),
    .out_ready(out_ready), .out_valid(out_valid), .out_data(out_data),
    .out_head(out_head), .out_last(out_last), .done(done)
  );

  // independent distance of the presented header against the source
  logic [CW-1:0] hx, hy;
  logic [CW:0]   hdist;
  assign hx = out_data[CW-1:0];
  assign hy = out_data[2*CW-1:CW];
  assign hdist = ((hx > CW'(SRC_X)) ? {1'b0, hx} - (CW+1)'(SRC_X) : (CW+1)'(SRC_X) - {1'b0, hx})
               + ((hy > CW'(SRC_Y)) ? {1'b0, hy} - (CW+1)'(SRC_Y) : (CW+1)'(SRC_Y) - {1'b0, hy});

  // R3: local class lands one hop away
  a_r3_local_hop: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_head && want_local_q |-> hdist == (CW+1)'(1));
  // R4: remote class is neither the source nor a neighbour
  a_r4_remote_hop: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_head && !want_local_q |-> hdist > (CW+1)'(1));
  // R2: zero load never leaves idle
  a_r2_zero_load: assert property (@(posedge clk) disable iff (!rst_n)
    state == TG_IDLE && load_frac == '0 |=> state == TG_IDLE);
  // R7: source fields of the header follow the parameters
  a_r7_src_fields: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_head |-> out_data[4*CW-1:2*CW] == {CW'(SRC_Y), CW'(SRC_X)});
endmodule

// File: tb/loc_traffic_gen_tb_top.sv
`timescale 1ns/1ps
module tg_flow_mon #(
  parameter int SX = 0,
  parameter int SY = 0
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        valid,
  input  logic        ready,
  input  logic        head,
  input  logic        last,
  input  logic [31:0] data,
  input  logic [8:0]  loc_frac,
  output int          checks,
  output int          fails,
  output int          msgs,
  output int          flits,
  output int          n_near,
  output int          n_far,
  output logic        mid
);
  int          idx;
  int          hx, hy, hd;
  logic        pend;
  logic [31:0] pdata, ex;

  initial begin
    checks = 0; fails = 0; msgs = 0; flits = 0; n_near = 0; n_far = 0;
    idx = 0; pend = 1'b0; pdata = '0; mid = 1'b0;
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s src(%0d,%0d) actual=%h expected=%h", req, SX, SY, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (!rst_n) begin
      idx = 0; pend = 1'b0;
    end else begin
      if (pend) begin
        chk(valid, "R6 valid held", 32'(valid), 32'd1);
        chk(data == pdata, "R6 data held", data, pdata);
      end
      if (valid && ready) begin
        if (idx == 0) begin
          chk(head && !last, "R5 header flags", {30'd0, head, last}, 32'd2);
          ex = {20'd0, 3'(SY), 3'(SX), data[5:0]};
          chk(data == ex, "R7 header layout", data, ex);
          hx = int'(data[2:0]); hy = int'(data[5:3]);
          hd = ((hx > SX) ? hx - SX : SX - hx) + ((hy > SY) ? hy - SY : SY - hy);
          chk(hd != 0, "R4 not source", hd, 32'd1);
          if (loc_frac == 9'd256) chk(hd == 1, "R3 local hop", hd, 32'd1);
          if (loc_frac == 9'd0)   chk(hd > 1, "R4 remote hop", hd, 32'd2);
          if (hd == 1) n_near++; else n_far++;
          msgs++;
        end else begin
          chk(!head && (last == (idx == 63)), "R5 body flags",
              {30'd0, head, last}, {31'd0, 1'(idx == 63)});
          ex = {20'd0, 3'(SY), 3'(SX), 6'(idx)};
          chk(data == ex, "R8 data flit", data, ex);
        end
        idx = (idx == 63) ? 0 : idx + 1;
        flits++;
      end
      pend = valid && !ready;
      pdata = data;
    end
    mid = (idx != 0);
  end
endmodule

module loc_traffic_gen_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ready = 1'b0;
  logic [8:0]  load = '0;
  logic [8:0]  loc = '0;
  int          cyc = 0;
  int          rmode = 0;
  int          tchecks = 0, tfails = 0;

  logic        v_i, h_i, l_i, v_e, h_e, l_e;
  logic [31:0] d_i, d_e;
  int c_i, f_i, m_i, fl_i, nn_i, nf_i, c_e, f_e, m_e, fl_e, nn_e, nf_e;
  logic mid_i, mid_e;

  always #4 clk = ~clk;

  always @(posedge clk) begin
    cyc <= cyc + 1;
    #1;
    ready = (rmode == 0) ? 1'b1 : (((cyc * 5) % 11) > 3 && (cyc % 97) > 12);
  end

  loc_traffic_gen #(.SRC_X(0), .SRC_Y(0), .LFSR_SEED(16'hACE1)) dut_i (
    .clk(clk), .rst_n(rst_n), .load_frac(load), .local_frac(loc), .out_ready(ready),
    .out_valid(v_i), .out_data(d_i), .out_head(h_i), .out_last(l_i)
  );
  loc_traffic_gen #(.SRC_X(7), .SRC_Y(4), .LFSR_SEED(16'h1D2B)) dut_e (
    .clk(clk), .rst_n(rst_n), .load_frac(load), .local_frac(loc), .out_ready(ready),
    .out_valid(v_e), .out_data(d_e), .out_head(h_e), .out_last(l_e)
  );

  tg_flow_mon #(.SX(0), .SY(0)) mon_i (
    .clk(clk), .rst_n(rst_n), .valid(v_i), .ready(ready), .head(h_i), .last(l_i),
    .data(d_i), .loc_frac(loc), .checks(c_i), .fails(f_i), .msgs(m_i), .flits(fl_i),
    .n_near(nn_i), .n_far(nf_i), .mid(mid_i)
  );
  tg_flow_mon #(.SX(7), .SY(4)) mon_e (
    .clk(clk), .rst_n(rst_n), .valid(v_e), .ready(ready), .head(h_e), .last(l_e),
    .data(d_e), .loc_frac(loc), .checks(c_e), .fails(f_e), .msgs(m_e), .flits(fl_e),
    .n_near(nn_e), .n_far(nf_e), .mid(mid_e)
  );

  task automatic tchk(input bit ok, input string req, input int act, input int exp);
    tchecks++;
    if (!ok) begin
      tfails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("TB_RESULT checks=%0d failures=%0d", tchecks + c_i + c_e, tfails + f_i + f_e);
    $finish;
  endtask

  task automatic run(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic drain();
    @(posedge clk); #1 load = 9'd0;
    run(3000);
    tchk(!mid_i && !mid_e, "R5 no partial message after drain", int'(mid_i) + int'(mid_e), 0);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    tfails++;
    $display("FAIL watchdog expired actual=hung expected=finished");
    summary();
  end

  initial begin
    int a0, b0, a1, b1, s0, s1;
    run(4);
    tchk(!v_i && !v_e, "R1 valid low in reset", int'(v_i) + int'(v_e), 0);
    @(posedge clk); #1 rst_n = 1'b1;
    @(negedge clk);
    tchk(!v_i && !v_e, "R1 valid low after reset", int'(v_i) + int'(v_e), 0);
    run(500);
    tchk(fl_i + fl_e == 0, "R2 zero load emits nothing", fl_i + fl_e, 0);

    // all-local, free flowing
    @(posedge clk); #1 loc = 9'd256; load = 9'd256; rmode = 0;
    a0 = m_i; b0 = m_e;
    run(6000);
    tchk(m_i - a0 >= 3, "R10 corner source completes local draws", m_i - a0, 3);
    tchk(m_e - b0 >= 3, "R10 edge source completes local draws", m_e - b0, 3);
    tchk(nf_i + nf_e == 0, "R3 no remote header in local mode", nf_i + nf_e, 0);
    drain();
    s0 = fl_i + fl_e;
    run(1500);
    tchk(fl_i + fl_e == s0, "R2 zero load window", fl_i + fl_e, s0);

    // all-remote, stuttering ready
    @(posedge clk); #1 loc = 9'd0; load = 9'd256; rmode = 1;
    a0 = m_i; b0 = m_e; a1 = nn_i; b1 = nn_e;
    run(8000);
    tchk(m_i > a0 && m_e > b0, "R4 remote messages produced", (m_i - a0) + (m_e - b0), 2);
    tchk(nn_i == a1 && nn_e == b1, "R4 no neighbour in remote mode", (nn_i - a1) + (nn_e - b1), 0);
    drain();

    // mixed class, partial load
    @(posedge clk); #1 loc = 9'd128; load = 9'd64; rmode = 1;
    a0 = nn_i; b0 = nf_i; a1 = nn_e; b1 = nf_e;
    run(16000);
    tchk(nn_i > a0 && nf_i > b0, "R9 corner mixes classes", (nn_i - a0) * 1000 + (nf_i - b0), 1001);
    tchk(nn_e > a1 && nf_e > b1, "R9 edge mixes classes", (nn_e - a1) * 1000 + (nf_e - b1), 1001);
    drain();
    s1 = fl_i + fl_e;
    tchk(s1 % 64 == 0, "R5 flit total is whole messages", s1 % 64, 0);
    summary();
  end
endmodule